// File: doc/BRIEF.md
# Low-Transition Scan Stimulus Generator

This block produces pseudo-random serial stimulus for a test-per-scan self-test session. The scan data is shaped so that successive bits in a vector tend to repeat, which cuts toggling in the scan chain while it shifts. A Fibonacci LFSR runs one step per shift cycle. A few of its state bits, spread evenly across the register, are combined by an AND gate. That AND result drives a toggle flip-flop. The flip-flop output is the only serial scan-in bit. When the AND result is 0 the bit repeats, and when it is 1 the bit flips. Long runs of equal bits therefore enter the chain.

A controller sequences the session. After a start request, scan-enable stays high for exactly one chain length of cycles. Then it drops for a single capture cycle, marked by a one-cycle capture pulse. The shift and capture steps repeat until the requested number of vectors has been applied. The done flag then rises and stays high until the next session. The LFSR can be seeded between sessions. A zero seed is replaced by a fixed non-zero value, so the register cannot lock up. The scan chain and the circuit under test lie outside this block.

Top module: `lowTransScanGen`

## Requirements
- R1: After reset, scanEn, capture, done and scanIn are all 0, and the LFSR holds the default seed 16'hACE1.
- R2: A seedLoad pulse while no session is active loads seedData into the LFSR. An all-zero seedData loads 16'hACE1 instead.
- R3: The LFSR is a left-shifting Fibonacci register. The new bit 0 is the XOR of the state bits selected by the polynomial mask (default 16'hB400, i.e. x^16+x^14+x^13+x^11+1). It advances exactly once per cycle with scanEn high and holds in every other cycle, including between sessions.
- R4: The AND stage combines AND_K LFSR bits at indices i*(LFSR_W/AND_K) for i = 0..AND_K-1. With the defaults, these are bits 0, 5 and 10.
- R5: scanIn comes only from the toggle flip-flop. In each shift cycle, the next shift bit equals the current bit XOR the AND of the selected taps in the current LFSR state. It is unchanged when that AND is 0.
- R6: Accepting start clears the toggle flip-flop, so the first bit shifted in a session is 0.
- R7: Each vector has scanEn high for exactly CHAIN_LEN (default 12) consecutive cycles.
- R8: Straight after the last shift cycle of a vector comes a single cycle with capture high and scanEn low. If more vectors remain, shifting resumes in the cycle after the capture cycle.
- R9: The session ends after numVectors capture pulses. done goes high in the cycle after the final capture and stays high while idle. Accepting the next start clears it.
- R10: A start with numVectors equal to 0 raises done in the next cycle with no shift or capture cycle.
- R11: start and seedLoad have no effect while a session is active. The LFSR sequence and the vector count carry on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a session (accepted when idle) |
| seedLoad | input | 1 | Load seedData into the LFSR (accepted when idle) |
| seedData | input | LFSR_W | Seed value; zero is replaced by the default seed |
| numVectors | input | VEC_W | Vectors to apply in the session being started |
| scanIn | output | 1 | Serial scan data from the toggle flip-flop |
| scanEn | output | 1 | High during shift cycles |
| capture | output | 1 | One-cycle pulse in the capture cycle |
| done | output | 1 | Session finished; held until next start |

## Verification
The assertions assume that start and seedLoad are synchronous single-cycle levels. They also assume that reset is held for at least one clock edge before any request, so that the state register starts from idle. The stimulus drives every input on the falling edge and drops each request after one cycle. It deliberately raises start and seedLoad together in the middle of a session to show that both are ignored there. The bench keeps its own LFSR and toggle model and advances them only on cycles where it sees scanEn high. This checks each shifted bit against the previous one and confirms that no step is gained or lost across capture cycles, idle gaps or ignored seed loads.

// File: rtl/ltsgPkg.sv
package ltsgPkg;
  // strobes issued by the sequencer to the stimulus datapath
  typedef struct packed {
    logic clearTff;
    logic advance;
    logic loadSeed;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SHIFT   = 2'd1,
    ST_CAPTURE = 2'd2
  } state_t;
endpackage

// File: rtl/ltsgDatapath.sv
module ltsgDatapath
  import ltsgPkg::*;
#(
  parameter int              LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] POLY_MASK    = 16'hB400,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 16'hACE1,
  parameter int              AND_K        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [LFSR_W-1:0] seedData,
  output logic              scanIn
);
  localparam int TAP_STEP = LFSR_W / AND_K;

  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;
  logic [LFSR_W-1:0] seedSafe;
  logic [AND_K-1:0]  tapBits;
  logic              feedback;
  logic              andOut;
  logic              tffQ;

  // evenly spread AND taps (R4)
  for (genvar i = 0; i < AND_K; i++) begin : g_tap
    assign tapBits[i] = lfsrQ[i*TAP_STEP];
  end

  always_comb begin
    andOut   = &tapBits;
    feedback = ^(lfsrQ & POLY_MASK);
    lfsrNext = {lfsrQ[LFSR_W-2:0], feedback};
    seedSafe = (seedData == '0) ? DEFAULT_SEED : seedData;
  end

  // LFSR: steps only on shift cycles (R3), loads a safe seed (R2)
  always_ff @(posedge clk) begin
    if (!rstN)              lfsrQ <= DEFAULT_SEED;
    else if (strb.loadSeed) lfsrQ <= seedSafe;
    else if (strb.advance)  lfsrQ <= lfsrNext;
  end

  // toggle flip-flop: flips when the AND is 1, holds otherwise (R5, R6)
  always_ff @(posedge clk) begin
    if (!rstN)              tffQ <= 1'b0;
    else if (strb.clearTff) tffQ <= 1'b0;
    else if (strb.advance)  tffQ <= tffQ ^ andOut;
  end

  assign scanIn = tffQ;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0); // R3
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.loadSeed) |=> $stable(lfsrQ)); // R3
  AST_TFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearTff && !(strb.advance && andOut)) |=> $stable(tffQ)); // R5
  AST_TFF_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearTff && strb.advance && andOut) |=> (tffQ != $past(tffQ))); // R5
  AST_TFF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearTff |=> !tffQ); // R6
endmodule

// File: rtl/ltsgCtrl.sv
module ltsgCtrl
  import ltsgPkg::*;
#(
  parameter int CHAIN_LEN = 12,
  parameter int VEC_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             seedLoad,
  input  logic [VEC_W-1:0] numVectors,
  output strobe_t          strb,
  output logic             scanEn,
  output logic             capture,
  output logic             done
);
  localparam int CNT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;

  state_t           state;
  logic [CNT_W-1:0] shiftCnt;
  logic [VEC_W-1:0] vecCnt;
  logic [VEC_W-1:0] vecTarget;
  logic             doneQ;
  logic             idle;
  logic             lastShift;
  logic             lastVec;

  always_comb begin
    idle          = (state == ST_IDLE);
    lastShift     = (shiftCnt == CNT_W'(CHAIN_LEN - 1));
    lastVec       = ({1'b0, vecCnt} + (VEC_W+1)'(1)) == {1'b0, vecTarget};
    strb.loadSeed = idle && seedLoad;              // R11: idle only
    strb.clearTff = idle && start;                 // R6
    strb.advance  = (state == ST_SHIFT);           // R3
    scanEn        = (state == ST_SHIFT);
    capture       = (state == ST_CAPTURE);
    done          = doneQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      shiftCnt  <= '0;
      vecCnt    <= '0;
      vecTarget <= '0;
      doneQ     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            shiftCnt  <= '0;
            vecCnt    <= '0;
            vecTarget <= numVectors;
            if (numVectors == '0) begin
              doneQ <= 1'b1;                        // R10
            end else begin
              doneQ <= 1'b0;                        // R9
              state <= ST_SHIFT;
            end
          end
        end
        ST_SHIFT: begin
          if (lastShift) begin
            shiftCnt <= '0;
            state    <= ST_CAPTURE;                 // R7, R8
          end else begin
            shiftCnt <= shiftCnt + CNT_W'(1);
          end
        end
        ST_CAPTURE: begin
          vecCnt <= vecCnt + VEC_W'(1);
          if (lastVec) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;                          // R9
          end else begin
            state <= ST_SHIFT;                      // R8
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |-> ({1'b0, shiftCnt} < (CNT_W+1)'(CHAIN_LEN))); // R7
  AST_CAPTURE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (scanEn && lastShift) |=> (capture && !scanEn)); // R8
  AST_CAPTURE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> !capture); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!scanEn && !capture)); // R9
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && start) |=> $stable(vecTarget)); // R11
  AST_ZERO_VECTORS: assert property (@(posedge clk) disable iff (!rstN)
    (idle && start && numVectors == '0) |=> (done && !scanEn)); // R10
endmodule

// File: rtl/lowTransScanGen.sv
module lowTransScanGen
  import ltsgPkg::*;
#(
  parameter int                LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] POLY_MASK    = 16'hB400,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 16'hACE1,
  parameter int                AND_K        = 3,
  parameter int                CHAIN_LEN    = 12,
  parameter int                VEC_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              seedLoad,
  input  logic [LFSR_W-1:0] seedData,
  input  logic [VEC_W-1:0]  numVectors,
  output logic              scanIn,
  output logic              scanEn,
  output logic              capture,
  output logic              done
);
  strobe_t strb;

  ltsgCtrl #(
    .CHAIN_LEN(CHAIN_LEN),
    .VEC_W    (VEC_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .seedLoad  (seedLoad),
    .numVectors(numVectors),
    .strb      (strb),
    .scanEn    (scanEn),
    .capture   (capture),
    .done      (done)
  );

  ltsgDatapath #(
    .LFSR_W      (LFSR_W),
    .POLY_MASK   (POLY_MASK),
    .DEFAULT_SEED(DEFAULT_SEED),
    .AND_K       (AND_K)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .seedData(seedData),
    .scanIn  (scanIn)
  );
endmodule

// File: tb/tb_lowTransScanGen.sv
module tb_lowTransScanGen;
  localparam int          W     = 16;
  localparam int          K     = 3;
  localparam int          CHAIN = 12;
  localparam logic [W-1:0] DEF  = 16'hACE1;
  localparam logic [W-1:0] POLY = 16'hB400;

  // session table: load flag, seed, vector count, cycle at which start+seedLoad are poked (0 = none)
  localparam int           N_SESS = 5;
  localparam bit           LOADS [N_SESS] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [W-1:0] SEEDS [N_SESS] = '{16'h0000, 16'h0000, 16'h0000, 16'h8001, 16'h0000};
  localparam int           NVECS [N_SESS] = '{3, 2, 4, 1, 5};
  localparam int           POKES [N_SESS] = '{5, 15, 0, 7, 30};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic seedLoad = 1'b0;
  logic [W-1:0] seedData = '0;
  logic [7:0] numVectors = '0;
  logic scanIn, scanEn, capture, done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [W-1:0] modelLfsr;
  logic modelTff;

  always #5 clk = ~clk;

  lowTransScanGen dut (
    .clk(clk), .rstN(rstN), .start(start), .seedLoad(seedLoad),
    .seedData(seedData), .numVectors(numVectors),
    .scanIn(scanIn), .scanEn(scanEn), .capture(capture), .done(done)
  );

  function automatic logic tapAnd(input logic [W-1:0] s);
    logic r = 1'b1;
    for (int i = 0; i < K; i++) r = r & s[i*(W/K)];
    return r;
  endfunction

  function automatic logic [W-1:0] lfsrStep(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & POLY)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  task automatic runSession(input bit doLoad, input logic [W-1:0] seed, input int nvec, input int poke);
    int run = 0;
    int caps = 0;
    int bits = 0;
    int cyc = 0;
    bit prevCap = 1'b0;
    if (doLoad) begin
      @(negedge clk); seedLoad = 1'b1; seedData = seed;
      @(negedge clk); seedLoad = 1'b0;
      modelLfsr = (seed == '0) ? DEF : seed;      // R2
    end
    @(negedge clk); numVectors = 8'(nvec); start = 1'b1;
    @(negedge clk); start = 1'b0;
    modelTff = 1'b0;
    check(done == 1'b0, "R9 done cleared by start", 32'(done), 0);
    while (!done && cyc < 5000) begin
      if (scanEn) begin
        if (bits == 0) check(scanIn == 1'b0, "R6 first bit", 32'(scanIn), 0);
        check(scanIn == modelTff, "R5 shifted bit", 32'(scanIn), 32'(modelTff));
        modelTff  = modelTff ^ tapAnd(modelLfsr);
        modelLfsr = lfsrStep(modelLfsr);            // R3, R4
        run++; bits++;
      end
      if (capture) begin
        check(run == CHAIN, "R7 shift run length", 32'(run), CHAIN);
        check(scanEn == 1'b0, "R8 scanEn low in capture", 32'(scanEn), 0);
        caps++; run = 0;
      end else if (prevCap) begin
        check(scanEn == 1'b1, "R8 shift resumes after capture", 32'(scanEn), 1);
      end
      prevCap = capture;
      if (poke > 0 && cyc == poke) begin
        start = 1'b1; seedLoad = 1'b1; seedData = 16'h5A5A;   // R11
      end else begin
        start = 1'b0; seedLoad = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; seedLoad = 1'b0;
    check(done == 1'b1, "R9 done raised", 32'(done), 1);
    check(prevCap == 1'b1, "R9 done follows final capture", 32'(prevCap), 1);
    check(caps == nvec, "R9 R11 capture count", 32'(caps), 32'(nvec));
    repeat (3) @(negedge clk);
    check(done == 1'b1 && scanEn == 1'b0, "R9 done held while idle", {30'd0, done, scanEn}, 32'h2);
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    modelLfsr = DEF;
    modelTff  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scanEn == 1'b0 && capture == 1'b0 && done == 1'b0 && scanIn == 1'b0,
          "R1 reset outputs", {28'd0, scanEn, capture, done, scanIn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(scanEn == 1'b0 && done == 1'b0, "R1 idle after reset", {30'd0, scanEn, done}, 0);

    // R10 zero vectors
    numVectors = '0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b1, "R10 done for zero vectors", 32'(done), 1);
    check(scanEn == 1'b0 && capture == 1'b0, "R10 no shift", {30'd0, scanEn, capture}, 0);
    repeat (2) @(negedge clk);
    check(scanEn == 1'b0, "R10 stays idle", 32'(scanEn), 0);

    // table-driven sessions (first one runs from the reset seed, R1 R3)
    for (int s = 0; s < N_SESS; s++) begin
      runSession(LOADS[s], SEEDS[s], NVECS[s], POKES[s]);
      repeat (2) @(negedge clk);
    end

    // R2: seed loaded in idle changes the stream; idle does not step the LFSR (R3)
    runSession(1'b1, 16'h0001, 2, 0);
    runSession(1'b0, 16'h0000, 1, 0);
    finish();
  end
endmodule